// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the integer execution unit of a small load/store processor core. It is purely combinational. It takes two operands and a 3-bit operation select, and it returns a result word, a zero flag and a signed overflow flag. It performs bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Branch-on-equal is done by issuing a subtraction and testing the zero flag.

One adder serves every arithmetic operation. For subtraction and for the less-than compare, the second operand is inverted and the adder's carry-in is forced to 1, which gives A + ~B + 1. The adder uses two-level carry lookahead. Lookahead runs inside each group of `GROUP` bits, and a second lookahead runs across the group carries, so no carry passes through more than two lookahead levels before it reaches a sum bit.

The overflow flag is only reported. The surrounding core decides whether to trap on it.

Top module: `int_alu`

## Requirements
- R1: Operation code 3'b000 gives the bitwise AND of `a_in` and `b_in`.
- R2: Operation code 3'b001 gives the bitwise OR of `a_in` and `b_in`.
- R3: Operation code 3'b010 gives `a_in + b_in` modulo 2^WIDTH, with carries crossing every group boundary.
- R4: Operation code 3'b110 gives `a_in - b_in` modulo 2^WIDTH.
- R5: Operation code 3'b111 gives 1 in bit 0 and 0 in every other bit when `a_in < b_in` as two's complement values, and all zeros otherwise. This holds even when the difference `a_in - b_in` overflows.
- R6: `zero` is 1 exactly when every bit of `result` is 0. Under operation code 3'b110 it is therefore 1 exactly when `a_in == b_in`.
- R7: Under operation code 3'b010, `ovf` is 1 when both operands have the same sign bit and the sign bit of the result differs from it.
- R8: Under operation code 3'b110, `ovf` is 1 in two cases: a non-negative `a_in` minus a negative `b_in` gives a negative result, or a negative `a_in` minus a non-negative `b_in` gives a non-negative result.
- R9: `ovf` is 0 for an addition of operands with different sign bits, and for a subtraction of operands with equal sign bits.
- R10: `ovf` is 0 under operation codes 3'b000, 3'b001 and 3'b111.
- R11: Operation codes 3'b011, 3'b100 and 3'b101 give a result of all zeros and `ovf` 0, so `zero` reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand (minuend for subtract and compare) |
| b_in | input | WIDTH | Second operand (subtrahend for subtract and compare) |
| op_sel | input | 3 | Operation select: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than |
| result | output | WIDTH | Selected result word |
| zero | output | 1 | High when `result` is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract; 0 for every other operation |

## Verification
The adder is driven with carry chains that stop just short of a group boundary, cross one boundary, or run the full width (all ones plus one). This tells a correct group-carry lookahead apart from one that drops or duplicates a group carry. Signed corners pair the most positive and most negative values under add, subtract and compare. These separate a correct overflow rule from a carry-out-based one, and a sign-bit-only less-than decision from one corrected by overflow. Equal, opposite-sign and same-sign operand pairs show that the zero flag and the absence of overflow follow the operand signs. A pseudo-random sweep over all eight codes then compares every output with an arithmetic model.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  localparam int MSB  = WIDTH - 1;
  localparam int NGRP = WIDTH / GROUP;
  localparam int LOWG = NGRP - 1;

  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic             sub_en;
  logic [MSB:0]     b_eff;
  logic [MSB:0]     gen;
  logic [MSB:0]     prp;
  logic [MSB:0]     bit_c;
  logic [MSB:0]     sum;
  logic [LOWG-1:0]  grp_g;
  logic [LOWG-1:0]  grp_p;
  logic [NGRP-1:0]  grp_c;
  logic             c_out;
  logic             arith_ovf;
  logic             less;

  assign sub_en = (op_sel == OP_SUB) || (op_sel == OP_SLT);
  assign b_eff  = b_in ^ {WIDTH{sub_en}};
  assign gen    = a_in & b_eff;
  assign prp    = a_in ^ b_eff;

  always_comb begin
    logic g_acc;
    logic p_acc;
    grp_g = '0;
    grp_p = '0;
    for (int gi = 0; gi < LOWG; gi++) begin
      g_acc = 1'b0;
      p_acc = 1'b1;
      for (int k = 0; k < GROUP; k++) begin
        g_acc = gen[gi*GROUP+k] | (prp[gi*GROUP+k] & g_acc);
        p_acc = p_acc & prp[gi*GROUP+k];
      end
      grp_g[gi] = g_acc;
      grp_p[gi] = p_acc;
    end
  end

  always_comb begin
    logic acc;
    logic pp;
    grp_c    = '0;
    grp_c[0] = sub_en;
    for (int gi = 0; gi < LOWG; gi++) begin
      acc = grp_g[gi];
      pp  = grp_p[gi];
      for (int j = gi - 1; j >= 0; j--) begin
        acc = acc | (pp & grp_g[j]);
        pp  = pp & grp_p[j];
      end
      grp_c[gi+1] = acc | (pp & sub_en);
    end
  end

  always_comb begin
    logic acc;
    logic pp;
    bit_c = '0;
    for (int gi = 0; gi < NGRP; gi++) begin
      bit_c[gi*GROUP] = grp_c[gi];
      for (int k = 1; k < GROUP; k++) begin
        acc = gen[gi*GROUP+k-1];
        pp  = prp[gi*GROUP+k-1];
        for (int j = k - 2; j >= 0; j--) begin
          acc = acc | (pp & gen[gi*GROUP+j]);
          pp  = pp & prp[gi*GROUP+j];
        end
        bit_c[gi*GROUP+k] = acc | (pp & grp_c[gi]);
      end
    end
  end

  assign sum       = prp ^ bit_c;
  assign c_out     = gen[MSB] | (prp[MSB] & bit_c[MSB]);
  assign arith_ovf = bit_c[MSB] ^ c_out;
  assign less      = sum[MSB] ^ arith_ovf;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op_sel)
      OP_AND: result = a_in & b_in;
      OP_OR:  result = a_in | b_in;
      OP_ADD: begin result = sum; ovf = arith_ovf; end
      OP_SUB: begin result = sum; ovf = arith_ovf; end
      OP_SLT: result = {{(WIDTH-1){1'b0}}, less};
      default: begin result = '0; ovf = 1'b0; end
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/int_alu_checks.sv
module int_alu_checks #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf
);

  always_comb begin
    if (op_sel == 3'b110) begin
      assert_sub_zero_R6: assert (zero == (a_in == b_in))
        else $error("sub zero flag disagrees with operand equality");
    end
    if (op_sel == 3'b010 && a_in[WIDTH-1] != b_in[WIDTH-1]) begin
      assert_add_no_overflow_R9: assert (!ovf)
        else $error("overflow on opposite-sign add");
    end
    if (op_sel == 3'b110 && a_in[WIDTH-1] == b_in[WIDTH-1]) begin
      assert_sub_no_overflow_R9: assert (!ovf)
        else $error("overflow on same-sign subtract");
    end
    if (op_sel == 3'b000 || op_sel == 3'b001 || op_sel == 3'b111) begin
      assert_quiet_overflow_R10: assert (!ovf)
        else $error("overflow raised by non-arithmetic op");
    end
    if (op_sel == 3'b111) begin
      assert_slt_shape_R5: assert (result[WIDTH-1:1] == '0)
        else $error("compare result has upper bits set");
    end
    if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101) begin
      assert_unused_quiet_R11: assert (result == '0 && zero && !ovf)
        else $error("unused op code produced output");
    end
  end

endmodule

bind int_alu int_alu_checks #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
  .result(result), .zero(zero), .ovf(ovf)
);

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;

  logic        clk = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [2:0]  op_sel = 3'b000;
  logic [31:0] result;
  logic        zero;
  logic        ovf;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  int_alu u_dut (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
    .result(result), .zero(zero), .ovf(ovf)
  );

  function automatic logic [31:0] model_res(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b110: return a - b;
      3'b111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_ovf(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [32:0] wide;
    if (op == 3'b010) begin
      wide = {a[31], a} + {b[31], b};
      return wide[32] != wide[31];
    end
    if (op == 3'b110) begin
      wide = {a[31], a} - {b[31], b};
      return wide[32] != wide[31];
    end
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    op_sel = op;
    a_in   = a;
    b_in   = b;
    #1;
  endtask

  task automatic run_op(string tag, logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [31:0] er;
    er = model_res(op, a, b);
    apply(op, a, b);
    chk(tag, "result", result, er);
    chk(tag, "zero", {31'd0, zero}, {31'd0, er == 32'd0});
    chk(tag, "ovf", {31'd0, ovf}, {31'd0, model_ovf(op, a, b)});
  endtask

  task automatic t_idle();
    apply(3'b000, 32'd0, 32'd0);
    chk("R6", "idle result", result, 32'd0);
    chk("R6", "idle zero", {31'd0, zero}, 32'd1);
    chk("R10", "idle ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_logic();
    run_op("R1", 3'b000, 32'hF0F0_A5A5, 32'hFF00_0F0F);
    run_op("R1", 3'b000, 32'h5555_5555, 32'hAAAA_AAAA);
    run_op("R2", 3'b001, 32'hF0F0_0000, 32'h0000_0F0F);
    run_op("R2", 3'b001, 32'h0000_0000, 32'h0000_0000);
    apply(3'b001, 32'h8000_0000, 32'h8000_0000);
    chk("R10", "or ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_add();
    run_op("R3", 3'b010, 32'h0000_0007, 32'h0000_0006);
    run_op("R3", 3'b010, 32'h0000_000F, 32'h0000_0001);
    run_op("R3", 3'b010, 32'h0000_0007, 32'h0000_0001);
    run_op("R3", 3'b010, 32'h0FFF_FFFF, 32'h0000_0001);
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    chk("R3", "wrap result", result, 32'd0);
    chk("R6", "wrap zero", {31'd0, zero}, 32'd1);
    chk("R9", "wrap ovf", {31'd0, ovf}, 32'd0);
    apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    chk("R7", "pos+pos ovf", {31'd0, ovf}, 32'd1);
    chk("R7", "pos+pos result", result, 32'h8000_0000);
    run_op("R7", 3'b010, 32'h8000_0000, 32'h8000_0000);
    run_op("R7", 3'b010, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R9", 3'b010, 32'h7FFF_FFFF, 32'h8000_0000);
  endtask

  task automatic t_sub();
    run_op("R4", 3'b110, 32'd5, 32'd3);
    run_op("R4", 3'b110, 32'd3, 32'd5);
    run_op("R4", 3'b110, 32'h0001_0000, 32'h0000_0001);
    apply(3'b110, 32'h1234_5678, 32'h1234_5678);
    chk("R6", "equal zero", {31'd0, zero}, 32'd1);
    chk("R6", "equal result", result, 32'd0);
    apply(3'b110, 32'h1234_5678, 32'h1234_5679);
    chk("R6", "unequal zero", {31'd0, zero}, 32'd0);
    apply(3'b110, 32'h8000_0000, 32'h0000_0001);
    chk("R8", "neg-pos ovf", {31'd0, ovf}, 32'd1);
    chk("R8", "neg-pos result", result, 32'h7FFF_FFFF);
    run_op("R8", 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_op("R8", 3'b110, 32'h0000_0000, 32'h8000_0000);
    run_op("R9", 3'b110, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R9", 3'b110, 32'h7FFF_FFFF, 32'h0000_0000);
  endtask

  task automatic t_slt();
    apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);
    chk("R5", "-1<1", result, 32'd1);
    apply(3'b111, 32'h0000_0001, 32'hFFFF_FFFF);
    chk("R5", "1<-1", result, 32'd0);
    apply(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    chk("R5", "min<max", result, 32'd1);
    chk("R10", "slt ovf", {31'd0, ovf}, 32'd0);
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    chk("R5", "max<min", result, 32'd0);
    chk("R6", "slt false zero", {31'd0, zero}, 32'd1);
    run_op("R5", 3'b111, 32'd42, 32'd42);
    run_op("R5", 3'b111, 32'd41, 32'd42);
  endtask

  task automatic t_unused();
    for (int k = 3; k <= 5; k++) begin
      apply(3'(k), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      chk("R11", "unused result", result, 32'd0);
      chk("R11", "unused zero", {31'd0, zero}, 32'd1);
      chk("R11", "unused ovf", {31'd0, ovf}, 32'd0);
    end
  endtask

  task automatic t_sweep();
    logic [31:0] st;
    logic [31:0] a;
    logic [31:0] b;
    st = 32'hC0DE_1234;
    for (int n = 0; n < 400; n++) begin
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      a = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      b = (n % 7 == 0) ? a : st;
      run_op("R3_R4_R5_sweep", 3'(n % 8), a, b);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule